// File: doc/BRIEF.md
# Multi-Port Register Memory with Bit-Granular Write Enables

This block is a small memory built entirely from flip-flops. It has any number of synchronous write ports and any number of combinational read ports. Each write port has its own address, data word and per-port write gate. It also has a write-enable mask as wide as the data word, so one port can update a single bit, a nibble or the whole word in one cycle.

Each stored word computes its next value by passing the old value through a chain of per-port merge stages, taken in ascending port order. At every stage, a bit takes the port's data bit only when the port addresses that word, its gate is open, and its mask bit for that position is set. Several ports may therefore write disjoint bits of one word in the same cycle. When they overlap, the highest-numbered port decides. All words share one clock, and a parameter selects which edge of that clock updates the storage.

Top module: `mpmem_top`

## Requirements
- R1: A write changes only the bits of the addressed word whose write-enable mask bit is 1. The other bits of that word keep their previous value.
- R2: Port p's fields sit in the flat buses at fixed offsets: the gate at bit p of `wr_ce`, the address at bits p*ABITS..p*ABITS+ABITS-1 of `wr_addr`, and the data and mask at bits p*WIDTH..p*WIDTH+WIDTH-1 of `wr_data` and `wr_en`. Read port r uses the same scheme with ABITS for `rd_addr` and WIDTH for `rd_data`.
- R3: Words that no port addresses in a cycle keep their contents.
- R4: When two or more ports write the same bit of the same word in one cycle, the data from the highest-numbered of those ports is stored.
- R5: A port whose `wr_ce` bit is 0 changes nothing, whatever its address, data and mask.
- R6: A port with an all-zero mask changes nothing.
- R7: A read port returns the stored word at its address combinationally. A write becomes visible only after the active clock edge, not in the cycle in which it is presented.
- R8: While `rst_n` is 0 at an active clock edge, every word is cleared to zero. The reset is synchronous.
- R9: A write to an address of DEPTH or above changes no word.
- R10: A read at an address of DEPTH or above returns zero.
- R11: Writes from different ports to disjoint bits of one word in the same cycle all take effect, and the results merge into that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Storage clock; the active edge is set by parameter WR_EDGE |
| rst_n | input | 1 | Synchronous active-low clear of all words |
| wr_ce | input | NWR | Per-port write gate, bit p for port p |
| wr_addr | input | NWR*ABITS | Packed write addresses |
| wr_data | input | NWR*WIDTH | Packed write data |
| wr_en | input | NWR*WIDTH | Packed per-bit write-enable masks |
| rd_addr | input | NRD*ABITS | Packed read addresses |
| rd_data | output | NRD*WIDTH | Packed read data, combinational |

## Verification
The bench targets four corner cases:
- All ports hit one word with full masks. A reversed or broken priority chain would store a lower port's data.
- Two ports write complementary nibbles of one word. A design that gated the whole word with one enable would lose one half.
- Writes use a closed gate, an empty mask, or an address past DEPTH. A missing qualifier or an aliased address would corrupt a real word.
- Reads are taken before the edge that commits a write. A design that bypassed write data to the read ports would show the new value early.

A behavioural model also compares both read ports against random traffic every cycle, with out-of-range addresses included.

// File: rtl/mpmem_pkg.sv
// Package: shared definitions for the multi-port register memory.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mpmem_pkg;

    // Which clock edge commits writes into storage.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } clk_edge_e;

endpackage

// File: rtl/mpmem_wsel.sv
// Module: per-write-port select decoder.
// Turns one port's gate, address and bit mask into a per-word, per-bit
// select vector: word w receives the mask when the port targets w, else 0.
// Assumes addresses at or above DEPTH match no word.
module mpmem_wsel #(
    parameter int WIDTH = 8,
    parameter int ABITS = 3,
    parameter int DEPTH = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_i,
    input  logic [ABITS-1:0]       addr_i,
    input  logic [WIDTH-1:0]       en_i,
    output logic [DEPTH*WIDTH-1:0] sel_o
);

    // Decode the target word and hand the mask to that word only.
    always_comb begin
        sel_o = '0;
        for (int w = 0; w < DEPTH; w++) begin
            if (ce_i && (int'(addr_i) == w)) begin
                sel_o[w*WIDTH +: WIDTH] = en_i;
            end
        end
    end

    // R9: an address past the last word selects nothing.
    a_r9_oor_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) >= DEPTH) |-> (sel_o == '0));

    // R5: a closed gate selects nothing.
    a_r5_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_i) |-> (sel_o == '0));

    // R6: an empty mask selects nothing.
    a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> (sel_o == '0));

endmodule

// File: rtl/mpmem_word.sv
// Module: one storage word with its write-merge chain.
// Stage p of the chain takes port p's data in the bits port p selects.
// Later stages override earlier ones, so the highest port index wins.
// Assumes all ports share one clock; WR_EDGE picks the active edge.
module mpmem_word
    import mpmem_pkg::*;
#(
    parameter int        WIDTH   = 8,
    parameter int        NWR     = 3,
    parameter clk_edge_e WR_EDGE = EDGE_RISE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NWR*WIDTH-1:0] sel_i,
    input  logic [NWR*WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0]     q_o
);

    logic [WIDTH-1:0] word_q;
    logic [WIDTH-1:0] chain [NWR+1];
    logic [WIDTH-1:0] any_sel;

    assign chain[0] = word_q;
    assign q_o      = word_q;

    // One merge stage per port, in ascending priority.
    for (genvar p = 0; p < NWR; p++) begin : g_stage
        assign chain[p+1] = (chain[p] & ~sel_i[p*WIDTH +: WIDTH])
                          | (wdata_i[p*WIDTH +: WIDTH] & sel_i[p*WIDTH +: WIDTH]);
    end

    // Collect every bit that any port touches this cycle.
    always_comb begin
        any_sel = '0;
        for (int p = 0; p < NWR; p++) begin
            any_sel = any_sel | sel_i[p*WIDTH +: WIDTH];
        end
    end

    if (WR_EDGE == EDGE_RISE) begin : g_rise
        // Commit the merged word, or clear it under reset.
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= chain[NWR];
        end

        // R3 / R1: bits no port selected keep their value.
        a_r3_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (((word_q ^ $past(word_q)) & ~$past(any_sel)) == '0));

        // R4: the highest port's selected bits carry its data.
        a_r4_top_port_wins: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (((word_q ^ $past(wdata_i[(NWR-1)*WIDTH +: WIDTH]))
                       & $past(sel_i[(NWR-1)*WIDTH +: WIDTH])) == '0));

        // R8: a reset edge leaves the word at zero.
        a_r8_reset_clears: assert property (@(posedge clk)
            (!rst_n) |=> (word_q == '0));
    end else begin : g_fall
        // Commit the merged word on the falling edge, or clear it.
        always_ff @(negedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= chain[NWR];
        end
    end

endmodule

// File: rtl/mpmem_rdport.sv
// Module: combinational read port.
// Returns the addressed word, or zero for an address past the last word.
// Assumes the storage is presented as one flat vector, word w at w*WIDTH.
module mpmem_rdport #(
    parameter int WIDTH = 8,
    parameter int ABITS = 3,
    parameter int DEPTH = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEPTH*WIDTH-1:0] words_i,
    input  logic [ABITS-1:0]       addr_i,
    output logic [WIDTH-1:0]       data_o
);

    // Select the addressed word; nothing matches out of range.
    always_comb begin
        data_o = '0;
        for (int w = 0; w < DEPTH; w++) begin
            if (int'(addr_i) == w) data_o = words_i[w*WIDTH +: WIDTH];
        end
    end

    // R10: out-of-range reads return zero.
    a_r10_oor_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr_i) >= DEPTH) |-> (data_o == '0));

endmodule

// File: rtl/mpmem_top.sv
// Module: multi-port register memory with per-bit write enables.
// NWR synchronous write ports and NRD combinational read ports over DEPTH
// words of WIDTH bits. Port fields are packed in flat buses at p*WIDTH
// and p*ABITS. Reset is synchronous, active low, and clears every word.
module mpmem_top
    import mpmem_pkg::*;
#(
    parameter int        WIDTH   = 8,
    parameter int        ABITS   = 3,
    parameter int        DEPTH   = 6,
    parameter int        NWR     = 3,
    parameter int        NRD     = 2,
    parameter clk_edge_e WR_EDGE = EDGE_RISE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NWR-1:0]       wr_ce,
    input  logic [NWR*ABITS-1:0] wr_addr,
    input  logic [NWR*WIDTH-1:0] wr_data,
    input  logic [NWR*WIDTH-1:0] wr_en,
    input  logic [NRD*ABITS-1:0] rd_addr,
    output logic [NRD*WIDTH-1:0] rd_data
);

    localparam int SELW = DEPTH * WIDTH;
    localparam int PORTW = NWR * WIDTH;

    logic [SELW-1:0]  port_sel [NWR];
    logic [PORTW-1:0] word_sel [DEPTH];
    logic [SELW-1:0]  mem_flat;

    // One select decoder per write port.
    for (genvar p = 0; p < NWR; p++) begin : g_wport
        mpmem_wsel #(.WIDTH(WIDTH), .ABITS(ABITS), .DEPTH(DEPTH)) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .ce_i   (wr_ce[p]),
            .addr_i (wr_addr[p*ABITS +: ABITS]),
            .en_i   (wr_en[p*WIDTH +: WIDTH]),
            .sel_o  (port_sel[p])
        );
    end

    // One storage word per address, fed by every port's select slice.
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        for (genvar p = 0; p < NWR; p++) begin : g_route
            assign word_sel[w][p*WIDTH +: WIDTH] = port_sel[p][w*WIDTH +: WIDTH];
        end

        mpmem_word #(.WIDTH(WIDTH), .NWR(NWR), .WR_EDGE(WR_EDGE)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (word_sel[w]),
            .wdata_i (wr_data),
            .q_o     (mem_flat[w*WIDTH +: WIDTH])
        );
    end

    // One combinational selector per read port.
    for (genvar r = 0; r < NRD; r++) begin : g_rport
        mpmem_rdport #(.WIDTH(WIDTH), .ABITS(ABITS), .DEPTH(DEPTH)) u_rd (
            .clk     (clk),
            .rst_n   (rst_n),
            .words_i (mem_flat),
            .addr_i  (rd_addr[r*ABITS +: ABITS]),
            .data_o  (rd_data[r*WIDTH +: WIDTH])
        );
    end

endmodule

// File: tb/mpmem_top_tb.sv
`timescale 1ns/1ps
// Bench: behavioural model of the memory, checked at every clock.
module mpmem_top_tb;

    localparam int WIDTH = 8;
    localparam int ABITS = 3;
    localparam int DEPTH = 6;
    localparam int NWR   = 3;
    localparam int NRD   = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NWR-1:0]       wr_ce = '0;
    logic [NWR*ABITS-1:0] wr_addr = '0;
    logic [NWR*WIDTH-1:0] wr_data = '0;
    logic [NWR*WIDTH-1:0] wr_en = '0;
    logic [NRD*ABITS-1:0] rd_addr = '0;
    logic [NRD*WIDTH-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int mdl [DEPTH];
    bit done = 1'b0;

    always #2 clk = ~clk;

    mpmem_top #(.WIDTH(WIDTH), .ABITS(ABITS), .DEPTH(DEPTH),
                .NWR(NWR), .NRD(NRD)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // Drive one write port (R2 packing).
    task automatic set_port(int p, bit ce, int a, int d, int e);
        wr_ce[p] = ce;
        wr_addr[p*ABITS +: ABITS] = ABITS'(a);
        wr_data[p*WIDTH +: WIDTH] = WIDTH'(d);
        wr_en[p*WIDTH +: WIDTH]   = WIDTH'(e);
    endtask

    task automatic idle_ports();
        for (int p = 0; p < NWR; p++) set_port(p, 1'b0, 0, 0, 0);
    endtask

    task automatic set_reads(int a0, int a1);
        rd_addr[0 +: ABITS]     = ABITS'(a0);
        rd_addr[ABITS +: ABITS] = ABITS'(a1);
    endtask

    // Compare both read ports, step one clock, update the model.
    task automatic tick(string tag);
        #1;
        for (int r = 0; r < NRD; r++) begin
            int a;
            int exp;
            a = int'(rd_addr[r*ABITS +: ABITS]);
            exp = (a < DEPTH) ? mdl[a] : 0;
            n_chk++;
            if (rd_data[r*WIDTH +: WIDTH] !== WIDTH'(exp)) begin
                n_fail++;
                $display("FAIL %s rport %0d addr %0d: actual %h expected %h",
                         tag, r, a, rd_data[r*WIDTH +: WIDTH], WIDTH'(exp));
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mdl[w] = 0;
        end else begin
            for (int p = 0; p < NWR; p++) begin
                int a;
                int d;
                int e;
                a = int'(wr_addr[p*ABITS +: ABITS]);
                d = int'(wr_data[p*WIDTH +: WIDTH]);
                e = int'(wr_en[p*WIDTH +: WIDTH]);
                if (wr_ce[p] && a < DEPTH) mdl[a] = (mdl[a] & ~e) | (d & e);
            end
        end
        @(negedge clk);
    endtask

    // Read every address (including out-of-range) with no writes.
    task automatic sweep(string tag);
        idle_ports();
        for (int a = 0; a < 8; a += 2) begin
            set_reads(a, a + 1);
            tick(tag);
        end
    endtask

    initial begin
        for (int w = 0; w < DEPTH; w++) mdl[w] = 0;
        @(posedge clk);
        @(negedge clk);
        tick("R8");
        sweep("R8");
        rst_n = 1'b1;

        // R1: port 1 writes only the low nibble of word 2.
        set_port(1, 1'b1, 2, 8'hA5, 8'h0F);
        set_reads(2, 3);
        tick("R7");
        idle_ports();
        tick("R1");
        // R2: port 2 writes word 5 in full; R3: neighbours untouched.
        set_port(2, 1'b1, 5, 8'h3C, 8'hFF);
        tick("R2");
        idle_ports();
        set_reads(5, 4);
        tick("R2");
        sweep("R3");

        // R4: all ports write word 1 with full masks.
        set_port(0, 1'b1, 1, 8'h11, 8'hFF);
        set_port(1, 1'b1, 1, 8'h22, 8'hFF);
        set_port(2, 1'b1, 1, 8'h44, 8'hFF);
        set_reads(1, 0);
        tick("R7");
        idle_ports();
        tick("R4");
        // R4: ports 0 and 1 overlap on word 0, port 1 wins.
        set_port(0, 1'b1, 0, 8'hFF, 8'hFF);
        set_port(1, 1'b1, 0, 8'h00, 8'h3C);
        tick("R4");
        idle_ports();
        tick("R4");

        // R11: complementary nibbles from two ports merge into word 3.
        set_port(0, 1'b1, 3, 8'h5A, 8'h0F);
        set_port(2, 1'b1, 3, 8'hC3, 8'hF0);
        set_reads(3, 2);
        tick("R11");
        idle_ports();
        tick("R11");

        // R5: gate closed; R6: empty mask.
        set_port(0, 1'b0, 3, 8'hFF, 8'hFF);
        set_port(1, 1'b1, 3, 8'hFF, 8'h00);
        tick("R5");
        idle_ports();
        tick("R6");

        // R9 / R10: out-of-range writes and reads.
        set_port(0, 1'b1, 6, 8'hEE, 8'hFF);
        set_port(2, 1'b1, 7, 8'hDD, 8'hFF);
        set_reads(6, 7);
        tick("R10");
        idle_ports();
        tick("R10");
        sweep("R9");

        // R8: mid-run reset clears everything.
        rst_n = 1'b0;
        set_port(1, 1'b1, 4, 8'h99, 8'hFF);
        tick("R8");
        rst_n = 1'b1;
        sweep("R8");

        // Random traffic over all ports and addresses.
        for (int i = 0; i < 1500; i++) begin
            for (int p = 0; p < NWR; p++) begin
                int m;
                m = (($urandom % 3) == 0) ? 'hFF : int'($urandom % 256);
                set_port(p, ($urandom % 4) != 0, int'($urandom % 8),
                         int'($urandom % 256), m);
            end
            set_reads(int'($urandom % 8), int'($urandom % 8));
            tick("R4");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule